// File: doc/BRIEF.md
# Address Translation Unit with Permission Checking

This block turns 32-bit virtual addresses into physical addresses through a small, fully associative translation cache. It also checks every access against the permissions of its page and the privilege of the requester. Pages are 4 KiB in size. The low twelve address bits pass through as the page offset, and the upper twenty bits are the page number that is looked up. Each request carries a read/write flag, a user/supervisor flag and a check-only flag. The response is either a physical address with a cacheable attribute, or a fault code that names a single cause.

A request that misses the cache stalls the requester. The unit then fetches the page-table entry from a single-level table in memory over a simple request/acknowledge port, installs the entry, and answers the original request. A request marked check-only is used when the requester's virtually indexed first-level cache already hit. For such a request the unit still runs the full permission check, but it withholds the address. A flush input empties the cache when the address space changes.

Top module: `xlat_unit`

## Requirements
- R1: On a granted access, resp_paddr[11:0] equals req_vaddr[11:0] and resp_paddr[31:12] equals bits 31:12 of the page-table entry.
- R2: A request accepted while req_ready is high and whose page is cached produces resp_valid in the next cycle, with no memory request.
- R3: On a miss, req_ready goes low and mem_req is held with a constant mem_addr, equal to the table base plus page number times 4, until mem_ack. resp_valid follows in the cycle after mem_ack.
- R4: Page-table entry format: bit 0 valid, bit 1 writable, bit 2 user-accessible, bit 3 cacheable, bits 31:12 frame number. On a grant, resp_cacheable copies bit 3.
- R5: resp_fault encodes 0 granted, 1 not mapped, 2 privilege violation (user access to a page without the user bit), 3 illegal write (write to a page without the writable bit). Priority is not mapped, then privilege, then write. Supervisor access and reads are never refused by the user and writable bits.
- R6: A faulting response drives resp_paddr and resp_cacheable to zero.
- R7: A check-only request is classified exactly like a normal one, and on a grant it returns resp_paddr equal to zero.
- R8: An entry fetched with the valid bit clear is not installed, so a repeat of the same request walks the table again.
- R9: An entry fetched with the valid bit set is installed, so a repeat of the same page is answered without a memory request.
- R10: The cache holds 8 entries and fills and replaces them in round-robin order. The ninth distinct installed page evicts the oldest one, and the later pages stay cached.
- R11: A one-cycle flush pulse invalidates every entry, so the next request to any page walks the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| table_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_check_only | input | 1 | Permission check only; address not wanted |
| req_ready | output | 1 | Unit idle and accepting a request |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_paddr | output | 32 | Physical address (zero on fault or check-only) |
| resp_cacheable | output | 1 | Cacheable attribute of the page |
| resp_fault | output | 2 | Fault code |
| mem_req | output | 1 | Table-entry fetch request |
| mem_addr | output | 32 | Address of the table entry |
| mem_ack | input | 1 | Fetch data valid |
| mem_rdata | input | 32 | Fetched page-table entry |

## Verification
The bench builds the unit with the default of 8 entries. It uses a memory model that answers a fetch two cycles after the request and computes each entry from its page number, so that the flag bits cycle through all sixteen combinations. With only 8 entries, nine distinct valid pages are enough to wrap the round-robin pointer and show which entry is evicted and which survives. The flag pattern makes every fault cause and every priority overlap reachable within a few pages.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int PN_W   = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_UNMAPPED = 2'd1,
        FLT_PRIV     = 2'd2,
        FLT_WRITE    = 2'd3
    } fault_e;

    typedef enum logic {
        W_IDLE  = 1'b0,
        W_FETCH = 1'b1
    } wstate_e;

    typedef struct packed {
        logic [PN_W-1:0] frame;
        logic            writable;
        logic            user_ok;
        logic            cacheable;
    } attr_t;

    typedef struct packed {
        logic            valid;
        logic [PN_W-1:0] page;
        attr_t           attr;
    } slot_t;

    typedef struct packed {
        fault_e            fault;
        logic [ADDR_W-1:0] paddr;
        logic              cacheable;
    } resp_t;

    function automatic attr_t pte_attr(input logic [ADDR_W-1:0] pte);
        attr_t a;
        a.frame     = pte[ADDR_W-1:OFF_W];
        a.writable  = pte[1];
        a.user_ok   = pte[2];
        a.cacheable = pte[3];
        return a;
    endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import mmu_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_page,
    output logic            hit,
    output attr_t           hit_attr,
    input  logic            install,
    input  logic [PN_W-1:0] ins_page,
    input  attr_t           ins_attr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] vld;
    logic [IDX_W-1:0]   victim;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign vld[g]   = slots[g].valid;
        assign match[g] = slots[g].valid && (slots[g].page == lk_page);
    end

    always_comb begin
        hit_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_attr = hit_attr | slots[i].attr;
        end
    end
    assign hit = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].valid <= 1'b0;
            victim <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].valid <= 1'b0;
        end else if (install) begin
            slots[victim].valid <= 1'b1;
            slots[victim].page  <= ins_page;
            slots[victim].attr  <= ins_attr;
            victim <= (victim == LAST) ? '0 : victim + 1'b1;
        end
    end

    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld == '0));

    assert_victim_moves_R10: assert property (@(posedge clk) disable iff (rst)
        (install && !flush) |=> (victim != $past(victim)));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_vaddr,
    input  logic              start_write,
    input  logic              start_user,
    input  logic              start_chk,
    input  logic [ADDR_W-1:0] table_base,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] held_vaddr,
    output logic              held_write,
    output logic              held_user,
    output logic              held_chk
);
    wstate_e           state;
    logic [ADDR_W-1:0] held_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
        end else begin
            case (state)
                W_IDLE:  if (start)   state <= W_FETCH;
                W_FETCH: if (mem_ack) state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == W_IDLE && start) begin
            held_vaddr <= start_vaddr;
            held_write <= start_write;
            held_user  <= start_user;
            held_chk   <= start_chk;
            held_base  <= table_base;
        end
    end

    assign busy     = (state == W_FETCH);
    assign mem_req  = busy;
    assign done     = busy && mem_ack;
    assign mem_addr = held_base + {held_vaddr[ADDR_W-1:OFF_W], 2'b00};

    assert_fetch_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_fetch_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import mmu_pkg::*;
(
    input  logic              mapped,
    input  attr_t             attr,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              write,
    input  logic              user,
    input  logic              chk,
    output resp_t             result
);
    always_comb begin
        result = '0;
        if (!mapped)                        result.fault = FLT_UNMAPPED;
        else if (user && !attr.user_ok)     result.fault = FLT_PRIV;
        else if (write && !attr.writable)   result.fault = FLT_WRITE;
        else                                result.fault = FLT_NONE;

        if (result.fault == FLT_NONE) begin
            result.cacheable = attr.cacheable;
            result.paddr     = chk ? '0 : {attr.frame, vaddr[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import mmu_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic [31:0] table_base,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic        req_check_only,
    output logic        req_ready,
    output logic        resp_valid,
    output logic [31:0] resp_paddr,
    output logic        resp_cacheable,
    output logic [1:0]  resp_fault,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    logic              hit, busy, walk_done, accept;
    attr_t             hit_attr, fetched_attr, chk_attr;
    logic [ADDR_W-1:0] held_vaddr, chk_vaddr;
    logic              held_write, held_user, held_chk;
    logic              chk_mapped, chk_write, chk_user, chk_only;
    resp_t             perm_out, resp_q;

    assign req_ready    = !busy;
    assign accept       = req_valid && req_ready;
    assign fetched_attr = pte_attr(mem_rdata);

    xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_page  (req_vaddr[ADDR_W-1:OFF_W]),
        .hit      (hit),
        .hit_attr (hit_attr),
        .install  (walk_done && mem_rdata[0]),
        .ins_page (held_vaddr[ADDR_W-1:OFF_W]),
        .ins_attr (fetched_attr)
    );

    xlat_walker u_walk (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && !hit),
        .start_vaddr (req_vaddr),
        .start_write (req_write),
        .start_user  (req_user),
        .start_chk   (req_check_only),
        .table_base  (table_base),
        .busy        (busy),
        .done        (walk_done),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .held_vaddr  (held_vaddr),
        .held_write  (held_write),
        .held_user   (held_user),
        .held_chk    (held_chk)
    );

    always_comb begin
        if (busy) begin
            chk_mapped = mem_rdata[0];
            chk_attr   = fetched_attr;
            chk_vaddr  = held_vaddr;
            chk_write  = held_write;
            chk_user   = held_user;
            chk_only   = held_chk;
        end else begin
            chk_mapped = 1'b1;
            chk_attr   = hit_attr;
            chk_vaddr  = req_vaddr;
            chk_write  = req_write;
            chk_user   = req_user;
            chk_only   = req_check_only;
        end
    end

    xlat_perm u_perm (
        .mapped (chk_mapped),
        .attr   (chk_attr),
        .vaddr  (chk_vaddr),
        .write  (chk_write),
        .user   (chk_user),
        .chk    (chk_only),
        .result (perm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_q     <= '0;
        end else begin
            resp_valid <= (accept && hit) || walk_done;
            if ((accept && hit) || walk_done) resp_q <= perm_out;
        end
    end

    assign resp_paddr     = resp_q.paddr;
    assign resp_cacheable = resp_q.cacheable;
    assign resp_fault     = resp_q.fault;

    assert_fault_hides_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'd0) |-> (resp_paddr == '0 && !resp_cacheable));

    assert_stall_during_walk_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_answer_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> resp_valid);

    assert_hit_answers_next_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !mem_req && !flush && $past(!mem_req)) |=> (resp_valid || mem_req));

endmodule

// File: tb/test_xlat_unit.sv
module test_xlat_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_check_only = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, resp_valid, resp_cacheable, mem_req;
    logic [31:0] resp_paddr, mem_addr;
    logic [1:0]  resp_fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0, n_fail = 0, walks = 0, lat = 0;
    bit finished = 0;
    logic [19:0] cur_page = '0;

    typedef struct packed {
        logic [1:0]  fault;
        logic [31:0] paddr;
        logic        c;
        logic        walk;
        logic [31:0] walks_at;
        logic [7:0]  rq;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_unit i_xlat_unit (
        .clk(clk), .rst(rst), .flush(flush), .table_base(BASE),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_user(req_user), .req_check_only(req_check_only), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_cacheable(resp_cacheable),
        .resp_fault(resp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Table entry per page: frame = page ^ 5A5A5, flags = page[3:0] (R4 format)
    function automatic logic [31:0] pte_of(logic [19:0] pg);
        return {pg ^ 20'h5A5A5, 8'h00, pg[3:0]};
    endfunction

    task automatic check(bit ok, int rq, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Memory model: answers two cycles after a request; checks the fetch address (R3)
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (lat == 2) begin
                    check(mem_addr == BASE + {10'b0, cur_page, 2'b00}, 3, mem_addr,
                          BASE + {10'b0, cur_page, 2'b00});
                    mem_rdata = pte_of(mem_addr[21:2] - BASE[21:2]);
                    mem_ack   = 1'b1;
                    walks++;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    // Monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    check(0, 2, 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(resp_fault == e.fault, e.rq, {30'b0, resp_fault}, {30'b0, e.fault});
                    check(resp_paddr == e.paddr, e.rq, resp_paddr, e.paddr);
                    check(resp_cacheable == e.c, e.rq, {31'b0, resp_cacheable}, {31'b0, e.c});
                    check((walks - int'(e.walks_at)) == int'(e.walk), e.rq,
                          walks - e.walks_at, {31'b0, e.walk});
                end
            end
        end
    end

    task automatic do_req(logic [31:0] va, bit wr, bit usr, bit chk, bit exp_walk, int rq);
        logic [31:0] pte;
        exp_t e;
        pte = pte_of(va[31:12]);
        e = '0;
        if (!pte[0])                e.fault = 2'd1;
        else if (usr && !pte[2])    e.fault = 2'd2;
        else if (wr && !pte[1])     e.fault = 2'd3;
        else                        e.fault = 2'd0;
        if (e.fault == 2'd0) begin
            e.c     = pte[3];
            e.paddr = chk ? 32'h0 : {pte[31:12], va[11:0]};
        end
        e.walk = exp_walk;
        e.rq   = 8'(rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_check_only = chk;
        req_valid = 1'b1;
        cur_page = va[31:12];
        e.walks_at = 32'(walks);
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state: idle, nothing pending
        check(req_ready == 1'b1, 2, {31'b0, req_ready}, 32'd1);
        check(resp_valid == 1'b0, 2, {31'b0, resp_valid}, 32'd0);
        check(mem_req == 1'b0, 3, {31'b0, mem_req}, 32'd0);

        // R1 R3 R4: page 0x0000F fully permissive, miss then grant
        do_req(32'h0000_F123, 0, 1, 0, 1, 1);
        // R9 R2: same page hits, no walk
        do_req(32'h0000_FABC, 0, 1, 0, 0, 9);
        // R1: user write allowed
        do_req(32'h0000_F004, 1, 1, 0, 0, 1);
        // R5: page 0x00011 supervisor-only read-only uncacheable; user read -> privilege
        do_req(32'h0001_1010, 0, 1, 0, 1, 5);
        // R5: supervisor write -> illegal write
        do_req(32'h0001_1010, 1, 0, 0, 0, 5);
        // R4: supervisor read granted, cacheable copies bit 3 (zero)
        do_req(32'h0001_1FFF, 0, 0, 0, 0, 4);
        // R5 priority: user write on the same page -> privilege before write
        do_req(32'h0001_1000, 1, 1, 0, 0, 5);
        // R8 R6: invalid page 0x00010, not mapped, walks every time
        do_req(32'h0001_0444, 0, 0, 0, 1, 8);
        do_req(32'h0001_0444, 1, 1, 0, 1, 8);
        // R7: check-only grant hides address; check-only still faults
        do_req(32'h0000_F777, 0, 1, 1, 0, 7);
        do_req(32'h0001_1777, 0, 1, 1, 0, 7);
        // R10: fill remaining six slots, then a ninth page evicts the oldest
        for (int k = 0; k < 6; k++) do_req({12'h0, 8'h21 + 8'(2*k), 12'h010}, 0, 0, 0, 1, 10);
        do_req(32'h0002_D020, 0, 0, 0, 1, 10);
        do_req(32'h0002_3030, 0, 0, 0, 0, 10);
        do_req(32'h0000_F040, 0, 0, 0, 1, 10);
        do_req(32'h0002_3050, 0, 0, 0, 0, 10);
        // R11: flush empties the cache
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        do_req(32'h0002_3060, 0, 0, 0, 1, 11);
        do_req(32'h0002_3070, 0, 0, 0, 0, 11);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule